// File: doc/BRIEF.md
# Low-Power Logic Self-Test Pattern Path

This block is the pattern and response datapath of a logic self-test engine built for low shift power. A maximal-length linear feedback shift register produces a pseudo-random bit stream. A phase shifter spreads that stream across several parallel scan chains. Before each chain input sits a hysteresis filter that only flips its output after repeated disagreement, so the bits shifted into the chains switch far less often than raw random bits would. Chain outputs are folded into a multiple-input signature register whose final value is compared against a known-good signature elsewhere.

A controller sequences the run. An accepted start reseeds the generator and clears the filters and the signature. The chains are then loaded for a chain length of cycles with scan enable high, followed by one capture cycle with scan enable low. This repeats for the programmed number of patterns. A last unload phase moves the final responses into the signature. Done then rises and the signature stays frozen until the next start. The filters only act on shift cycles, so capture-cycle activity is untouched.

Top module: `lpbist_path`

## Requirements
- R1: An accepted start loads the generator with `seed`, or with 1 when `seed` is zero. On every shift cycle the generator steps as a left-shifting Galois register: next = (s << 1) XOR (s[15] ? 0x002D : 0), which is the polynomial x^16+x^5+x^3+x^2+1. It holds on all other cycles.
- R2: The raw bit for chain i is the XOR of generator bits i mod 16, (3i+7) mod 16 and (5i+11) mod 16, taken from the generator value before the shift-cycle step.
- R3: Each chain has a filter with an output bit q and a count c in 0..H-1, with H = 2 by default. An accepted start clears both. On a shift cycle, a raw bit equal to q decrements c, saturating at 0. A differing raw bit either toggles q and clears c when c = H-1, or otherwise increments c. `scan_in[i]` is q. Two toggles of one chain input are therefore at least H shift cycles apart.
- R4: For a test length T, the run consists of T+1 shift phases of CHAIN_LEN cycles with `scan_en` high. Exactly one capture cycle with `scan_en` low separates consecutive phases. With T = 0 there is a single unload phase. Test lengths up to 2^18-1 are accepted.
- R5: In capture, idle and done cycles the generator, the filters and the signature all hold, so `scan_in` and `signature` do not change unless a start is accepted.
- R6: An accepted start clears the signature to 0. On each shift cycle it becomes (sig << 1) XOR (sig[15] ? 0x002D : 0) XOR `scan_out`, with chain i feeding bit i.
- R7: `done` rises in the cycle after the last unload shift. It then stays high with a stable signature until a start is accepted, which clears it.
- R8: A start is accepted only while idle or done. A start during a run is ignored, and `test_len` and `seed` are sampled only at an accepted start.
- R9: After reset, `scan_en`, `done`, `scan_in` and `signature` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted while idle or done) |
| test_len | input | TL_W | Number of patterns for the run |
| seed | input | LFSR_W | Generator seed (zero is replaced by 1) |
| scan_out | input | NUM_CHAINS | Serial outputs of the scan chains |
| scan_en | output | 1 | High on shift cycles, low on capture |
| scan_in | output | NUM_CHAINS | Filtered serial inputs to the scan chains |
| signature | output | LFSR_W | Response signature |
| done | output | 1 | Run complete, signature final |

## Verification
A wrong generator step or a wrong phase-shifter tap reaches the filters at once. It shows on `scan_in` within H shift cycles, as soon as a filter count reaches its toggle point. A corrupted filter count or output bit shows on `scan_in` at the next toggle. Any wrong signature step shows on `signature` in the very next cycle, and a counter error shows as a `scan_en` edge or a `done` rise one cycle early or late. The reference model follows every output cycle by cycle, so the first divergent cycle is reported.

// File: rtl/lpb_pkg.sv
package lpb_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SHIFT = 2'd1,
        PH_CAPT  = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;

    // Per-cycle control from the sequencer to the datapath
    typedef struct packed {
        logic init;   // accepted start: reseed and clear
        logic step;   // shift cycle: advance state
    } adv_t;

    localparam logic [15:0] DEF_POLY = 16'h002D;

    // Phase shifter tap index for one chain
    function automatic int tap_idx(input int chain, input int mul, input int off, input int w);
        return (chain * mul + off) % w;
    endfunction

endpackage

// File: rtl/lpb_lfsr.sv
module lpb_lfsr
    import lpb_pkg::*;
#(
    parameter int          W    = 16,
    parameter logic [W-1:0] POLY = W'(16'h002D)
) (
    input  logic         clk,
    input  logic         rst,
    input  adv_t         ctl,
    input  logic [W-1:0] seed,
    output logic [W-1:0] state
);
    logic [W-1:0] nxt;

    always_comb begin
        nxt = {state[W-2:0], 1'b0} ^ (state[W-1] ? POLY : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= W'(1);
        end else if (ctl.init) begin
            state <= (seed == '0) ? W'(1) : seed;
        end else if (ctl.step) begin
            state <= nxt;
        end
    end
endmodule

// File: rtl/lpb_phase_shift.sv
module lpb_phase_shift
    import lpb_pkg::*;
#(
    parameter int W = 16,
    parameter int K = 4
) (
    input  logic [W-1:0] src,
    output logic [K-1:0] bits
);
    for (genvar g = 0; g < K; g++) begin : g_tap
        localparam int TA = tap_idx(g, 1, 0, W);
        localparam int TB = tap_idx(g, 3, 7, W);
        localparam int TC = tap_idx(g, 5, 11, W);
        assign bits[g] = src[TA] ^ src[TB] ^ src[TC];
    end
endmodule

// File: rtl/lpb_smoother.sv
module lpb_smoother
    import lpb_pkg::*;
#(
    parameter int H = 2
) (
    input  logic clk,
    input  logic rst,
    input  adv_t ctl,
    input  logic din,
    output logic q
);
    localparam int CW = (H > 1) ? $clog2(H) : 1;
    localparam logic [CW-1:0] LAST = CW'(H - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || ctl.init) begin
            cnt <= '0;
            q   <= 1'b0;
        end else if (ctl.step) begin
            if (din == q) begin
                if (cnt != '0) cnt <= cnt - 1'b1;
            end else if (cnt == LAST) begin
                q   <= ~q;
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lpb_misr.sv
module lpb_misr
    import lpb_pkg::*;
#(
    parameter int           W    = 16,
    parameter int           K    = 4,
    parameter logic [W-1:0] POLY = W'(16'h002D)
) (
    input  logic         clk,
    input  logic         rst,
    input  adv_t         ctl,
    input  logic [K-1:0] din,
    output logic [W-1:0] sig
);
    logic [W-1:0] nxt;

    always_comb begin
        nxt = {sig[W-2:0], 1'b0} ^ (sig[W-1] ? POLY : '0) ^ W'(din);
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.init) begin
            sig <= '0;
        end else if (ctl.step) begin
            sig <= nxt;
        end
    end
endmodule

// File: rtl/lpb_ctrl.sv
module lpb_ctrl
    import lpb_pkg::*;
#(
    parameter int LEN = 8,
    parameter int TLW = 18
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [TLW-1:0] test_len,
    output adv_t           ctl,
    output phase_e         phase
);
    localparam int SW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [SW-1:0] SH_LAST = SW'(LEN - 1);

    logic [SW-1:0]  sh_cnt;
    logic [TLW-1:0] pat_cnt;
    logic [TLW-1:0] len_q;
    logic           accept;

    assign accept   = start && (phase == PH_IDLE || phase == PH_DONE);
    assign ctl.init = accept;
    assign ctl.step = (phase == PH_SHIFT);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            sh_cnt  <= '0;
            pat_cnt <= '0;
            len_q   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE, PH_DONE: begin
                    if (accept) begin
                        phase   <= PH_SHIFT;
                        sh_cnt  <= '0;
                        pat_cnt <= '0;
                        len_q   <= test_len;
                    end
                end
                PH_SHIFT: begin
                    if (sh_cnt == SH_LAST) begin
                        sh_cnt <= '0;
                        phase  <= (pat_cnt == len_q) ? PH_DONE : PH_CAPT;
                    end else begin
                        sh_cnt <= sh_cnt + 1'b1;
                    end
                end
                PH_CAPT: begin
                    pat_cnt <= pat_cnt + 1'b1;
                    phase   <= PH_SHIFT;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lpbist_path.sv
module lpbist_path
    import lpb_pkg::*;
#(
    parameter int                NUM_CHAINS   = 4,
    parameter int                CHAIN_LEN    = 8,
    parameter int                TL_W         = 18,
    parameter int                LFSR_W       = 16,
    parameter logic [LFSR_W-1:0] POLY         = LFSR_W'(DEF_POLY),
    parameter int                SMOOTH_DEPTH = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [TL_W-1:0]       test_len,
    input  logic [LFSR_W-1:0]     seed,
    input  logic [NUM_CHAINS-1:0] scan_out,
    output logic                  scan_en,
    output logic [NUM_CHAINS-1:0] scan_in,
    output logic [LFSR_W-1:0]     signature,
    output logic                  done
);
    adv_t                  ctl;
    phase_e                phase;
    logic [LFSR_W-1:0]     gen_state;
    logic [NUM_CHAINS-1:0] raw_bits;
    logic                  run_init;

    assign run_init = ctl.init;
    assign scan_en  = (phase == PH_SHIFT);
    assign done     = (phase == PH_DONE);

    lpb_ctrl #(.LEN(CHAIN_LEN), .TLW(TL_W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .test_len(test_len),
        .ctl(ctl), .phase(phase)
    );

    lpb_lfsr #(.W(LFSR_W), .POLY(POLY)) u_gen (
        .clk(clk), .rst(rst), .ctl(ctl), .seed(seed), .state(gen_state)
    );

    lpb_phase_shift #(.W(LFSR_W), .K(NUM_CHAINS)) u_pshift (
        .src(gen_state), .bits(raw_bits)
    );

    for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
        lpb_smoother #(.H(SMOOTH_DEPTH)) u_smooth (
            .clk(clk), .rst(rst), .ctl(ctl), .din(raw_bits[c]), .q(scan_in[c])
        );
    end

    lpb_misr #(.W(LFSR_W), .K(NUM_CHAINS), .POLY(POLY)) u_misr (
        .clk(clk), .rst(rst), .ctl(ctl), .din(scan_out), .sig(signature)
    );
endmodule

// File: rtl/lpbist_path_chk.sv
module lpbist_path_chk #(
    parameter int K   = 4,
    parameter int LEN = 8,
    parameter int W   = 16,
    parameter int H   = 2
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         init,
    input logic         scan_en,
    input logic         done,
    input logic [K-1:0] scan_in,
    input logic [W-1:0] signature
);
    localparam int RW = $clog2(LEN + 1) + 1;
    localparam int GW = $clog2(H + 1) + 1;

    logic [RW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) run_len <= '0;
        else if (scan_en) run_len <= (run_len < RW'(LEN)) ? run_len + 1'b1 : run_len;
        else run_len <= '0;
    end

    // R4: a shift phase never exceeds the chain length
    a_r4_shift_run_max: assert property (@(posedge clk) disable iff (rst)
        scan_en |-> run_len < RW'(LEN));

    // R4: every shift phase is exactly the chain length
    a_r4_shift_run_full: assert property (@(posedge clk) disable iff (rst)
        $fell(scan_en) |-> $past(run_len) == RW'(LEN - 1));

    // R5: quiet cycles leave outputs unchanged
    a_r5_quiet_hold: assert property (@(posedge clk) disable iff (rst)
        (!scan_en && !init) |=> ($stable(signature) && $stable(scan_in)));

    // R7: done holds with a frozen signature until a start
    a_r7_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(signature)));

    // R7: done rises straight after a shift cycle
    a_r7_done_after_unload: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(scan_en));

    logic       prev_en;
    logic [K-1:0] prev_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_en <= 1'b0;
            prev_in <= '0;
        end else begin
            prev_en <= scan_en;
            prev_in <= scan_in;
        end
    end

    for (genvar c = 0; c < K; c++) begin : g_gap
        logic [GW-1:0] gap;
        logic          tog;

        assign tog = prev_en && (scan_in[c] != prev_in[c]);

        always_ff @(posedge clk) begin
            if (rst || init) begin
                gap <= '0;
            end else if (tog) begin
                gap <= scan_en ? GW'(1) : '0;
            end else if (scan_en && gap < GW'(H)) begin
                gap <= gap + 1'b1;
            end
        end

        // R3: filtered input toggles at least H shift cycles apart
        a_r3_toggle_gap: assert property (@(posedge clk) disable iff (rst)
            tog |-> gap >= GW'(H));
    end
endmodule

bind lpbist_path lpbist_path_chk #(
    .K(NUM_CHAINS), .LEN(CHAIN_LEN), .W(LFSR_W), .H(SMOOTH_DEPTH)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .init(run_init), .scan_en(scan_en),
    .done(done), .scan_in(scan_in), .signature(signature)
);

// File: tb/test_lpbist_path.sv
module test_lpbist_path;
    localparam int K   = 4;
    localparam int L   = 8;
    localparam int TLW = 18;
    localparam int W   = 16;
    localparam int H   = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [TLW-1:0] test_len = '0;
    logic [W-1:0]   seed = '0;
    logic [K-1:0]   scan_out = '0;
    logic           scan_en, done;
    logic [K-1:0]   scan_in;
    logic [W-1:0]   signature;

    always #10 clk = ~clk;

    lpbist_path i_lpbist_path (
        .clk(clk), .rst(rst), .start(start), .test_len(test_len), .seed(seed),
        .scan_out(scan_out), .scan_en(scan_en), .scan_in(scan_in),
        .signature(signature), .done(done)
    );

    int n_chk = 0;
    int n_bad = 0;
    int wd    = 0;

    // Reference model state: phase 0 idle, 1 shift, 2 capture, 3 done
    int         mph, msh, mpc, mtl;
    logic [W-1:0] mlf, mmisr;
    logic [K-1:0] mq;
    int         mcnt [K];
    logic       pbit;

    function automatic logic [W-1:0] gal(input logic [W-1:0] s);
        return {s[W-2:0], 1'b0} ^ (s[W-1] ? 16'h002D : 16'h0000);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mph = 0; msh = 0; mpc = 0; mtl = 0;
            mlf = 16'h0001; mmisr = '0; mq = '0;
            for (int i = 0; i < K; i++) mcnt[i] = 0;
        end else if (start && (mph == 0 || mph == 3)) begin
            mlf = (seed == '0) ? 16'h0001 : seed;
            mmisr = '0; mq = '0;
            for (int i = 0; i < K; i++) mcnt[i] = 0;
            mph = 1; msh = 0; mpc = 0; mtl = int'(test_len);
        end else if (mph == 1) begin
            for (int i = 0; i < K; i++) begin
                pbit = mlf[i % W] ^ mlf[(3*i + 7) % W] ^ mlf[(5*i + 11) % W];
                if (pbit == mq[i]) begin
                    if (mcnt[i] > 0) mcnt[i] = mcnt[i] - 1;
                end else if (mcnt[i] == H - 1) begin
                    mq[i] = ~mq[i];
                    mcnt[i] = 0;
                end else begin
                    mcnt[i] = mcnt[i] + 1;
                end
            end
            mmisr = gal(mmisr) ^ W'(scan_out);
            mlf = gal(mlf);
            if (msh == L - 1) begin
                msh = 0;
                mph = (mpc == mtl) ? 3 : 2;
            end else begin
                msh = msh + 1;
            end
        end else if (mph == 2) begin
            mpc = mpc + 1;
            mph = 1;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input logic st);
        logic [31:0] r;
        @(negedge clk);
        chk("R4", "scan_en", longint'(scan_en), longint'(mph == 1));
        chk("R7", "done", longint'(done), longint'(mph == 3));
        chk("R6", "signature", longint'(signature), longint'(mmisr));
        chk("R1 R2 R3", "scan_in", longint'(scan_in), longint'(mq));
        start = st;
        r = $urandom;
        scan_out = r[K-1:0];
    endtask

    // R4 R8: one run; optional ignored start pulse with altered inputs
    task automatic run(input int tl, input logic [W-1:0] sd, input int poke_at);
        int sh = 0;
        int cap = 0;
        int guard = 0;
        test_len = TLW'(tl);
        seed = sd;
        tick(1'b1);
        do begin
            tick(guard == poke_at);
            if (guard == poke_at) begin
                test_len = TLW'(1);
                seed = 16'h0005;
            end
            if (scan_en) sh++;
            else if (!done) cap++;
            guard++;
        end while (!done && guard < 5000);
        chk("R4 R8", "shift cycles", longint'(sh), longint'((tl + 1) * L));
        chk("R4 R8", "capture cycles", longint'(cap), longint'(tl));
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 200000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected at most 200000", wd);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        @(negedge clk);
        chk("R9", "scan_en", longint'(scan_en), 0);
        chk("R9", "done", longint'(done), 0);
        chk("R9", "scan_in", longint'(scan_in), 0);
        chk("R9", "signature", longint'(signature), 0);
        repeat (3) tick(1'b0);

        run(2, 16'hACE1, -1);
        repeat (6) tick(1'b0);      // R7 hold in done
        run(0, 16'h5A5A, -1);       // R4 single unload
        repeat (2) tick(1'b0);
        run(3, 16'h0000, -1);       // R1 zero seed
        run(4, 16'h1234, 10);       // R8 start ignored mid-run
        repeat (3) tick(1'b0);
        run(20, 16'hBEEF, 30);      // R3 long stream, R5 captures
        run(1, 16'hFFFF, -1);
        repeat (4) tick(1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule